// File: doc/BRIEF.md
# Pipelined Address-Bus Arbiter with Parking

This block decides which of up to eight bus masters may drive the next address tenure. Every master raises a request line and receives one bit of a one-hot grant vector. The winner is the requester at the highest priority level. Among requesters that tie above the lowest level, the lowest index wins. Requesters that tie at level 0 take turns in least-recently-granted order, one tenure each. A master that holds the grant keeps it while it is still requesting, still at the top level, and no address retry is signalled. A master that tied at level 0 keeps it for one tenure only.

The bus reports three events: the start of each address tenure, the completion of each tenure, and address retries. From the start and completion pulses the arbiter counts outstanding tenures. It allows no new grant while two are outstanding, so the address pipeline never runs more than one level deep. Each master's level is either a fixed build-time default or its field in a programmable level vector, picked by a per-master enable bit. Level changes are registered, so the arbitration uses them one clock after they are written. When nobody requests, the grant can rest on a programmed master or on the last master granted, or be withdrawn.

Top module: `pipe_bus_arbiter`

## Requirements
- R1: The grant output is one-hot or all-zero. It is registered, so it reflects the inputs of the previous cycle. With no request, no pending hold, and parking mode 2'b00 or the reserved 2'b11, the grant is all-zero in the next cycle.
- R2: When the grant is open for arbitration, it goes to the requester with the numerically highest 2-bit level. Among requesters tied at a level above 0, the lowest index wins.
- R3: The current holder keeps the grant while it requests and its level equals the top requesting level, even if a lower-index master at the same level starts requesting.
- R4: An address retry breaks the hold, and arbitration takes place among the current requesters in that cycle.
- R5: A holder that starts an address tenure keeps the grant through the following cycle whatever its request line does. A retry or a full pipeline still removes the grant in that cycle.
- R6: A holder that tied at level 0 gives up the grant after its single tenure and the gap cycle. The next grant goes to the least recently granted level-0 requester. After reset, lower indices count as less recently granted.
- R7: The level of master i is taken from bits [2i+1:2i] of the programmable level vector when enable bit i is 1, and from the default otherwise. The default is level 0 for every master. A change first affects the grant two clock edges after it is applied, one edge to register it and one for the grant.
- R8: Each tenure start adds one to the outstanding count and each completion subtracts one, within the range 0 to 2. While the count is 2 the grant is all-zero. A completion that brings the count below 2 allows a grant again in the next cycle.
- R9: Parking mode 2'b01 grants the master named by the park-select input when there is no request and the pipeline is not full.
- R10: Parking mode 2'b10 grants the last master granted when there is no request and the pipeline is not full.
- R11: Reset, synchronous and active-low, clears the grant and the outstanding count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | N_MASTERS | Request per master |
| gnt_o | output | N_MASTERS | One-hot address-bus grant |
| tenure_start_i | input | 1 | Pulse: an address tenure begins |
| tenure_done_i | input | 1 | Pulse: a tenure (address and data) finished |
| addr_retry_i | input | 1 | Pulse: the current address tenure is retried |
| prio_en_i | input | N_MASTERS | Per-master select of the programmable level |
| prio_lvl_i | input | N_MASTERS*LVL_W | Programmable levels, LVL_W bits per master |
| park_mode_i | input | 2 | 00 none, 01 programmed master, 10 last master, 11 none |
| park_sel_i | input | IDX_W | Index of the programmed park master |

## Verification
The bench covers the corners where the hold rules interact. A lower-index peer arriving at the holder's level must not take the grant; a design that re-arbitrates every cycle would hand it over. A retry must move the grant at once; a design that ignores retry would keep the old holder. The cycle after a tenure start tests the gap rule: a design without it drops the grant when the master lowers its request for one cycle. The level-0 rotation must not let one master take a second tenure while a peer waits. The bench also checks the timing of a level change, which fails if the level registers are bypassed or doubled. It checks that the grant is withheld when the second outstanding tenure starts and is released again on completion.

// File: rtl/parb_pkg.sv
// Package: shared types for the pipelined bus arbiter.
// Assumes: no state; only encodings used by several modules.
package parb_pkg;

    // Idle-time grant policy; the reserved code behaves as no parking.
    typedef enum logic [1:0] {
        PARK_OFF   = 2'b00,
        PARK_FIXED = 2'b01,
        PARK_LAST  = 2'b10,
        PARK_RSVD  = 2'b11
    } park_mode_e;

endpackage

// File: rtl/parb_level_regs.sv
// Module: parb_level_regs
// Registers the effective priority level of each master. Each master's
// level comes from its programmable field when its enable bit is set, and
// from the build-time default otherwise.
// Assumes: the programmable inputs are static or change synchronously;
// the registered copy is what arbitration uses one clock later.
module parb_level_regs #(
    parameter int                           N_MASTERS  = 4,
    parameter int                           LVL_W      = 2,
    parameter logic [N_MASTERS*LVL_W-1:0]   DEF_LEVELS = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_MASTERS-1:0]        prio_en_i,
    input  logic [N_MASTERS*LVL_W-1:0]  prio_lvl_i,
    output logic [N_MASTERS*LVL_W-1:0]  lvl_o
);

    for (genvar m = 0; m < N_MASTERS; m++) begin : g_lvl
        logic [LVL_W-1:0] lvl_q;

        // Capture the selected level source for master m.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lvl_q <= DEF_LEVELS[m*LVL_W +: LVL_W];
            else if (prio_en_i[m])
                lvl_q <= prio_lvl_i[m*LVL_W +: LVL_W];
            else
                lvl_q <= DEF_LEVELS[m*LVL_W +: LVL_W];
        end

        assign lvl_o[m*LVL_W +: LVL_W] = lvl_q;
    end

endmodule

// File: rtl/parb_lru.sv
// Module: parb_lru
// Least-recently-granted ordering kept as a pairwise age matrix: bit
// (i*N+j) set means master i was granted less recently than master j.
// Picks the oldest candidate combinationally; moves the updated master to
// most-recent at the clock edge.
// Assumes: upd_i is one-hot or zero; the matrix stays a total order.
module parb_lru #(
    parameter int N_MASTERS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_MASTERS-1:0]  cand_i,
    input  logic [N_MASTERS-1:0]  upd_i,
    output logic [N_MASTERS-1:0]  pick_o
);

    localparam int NN = N_MASTERS * N_MASTERS;

    // Reset order: a lower index counts as older than a higher index.
    function automatic logic [NN-1:0] init_order();
        logic [NN-1:0] v;
        v = '0;
        for (int i = 0; i < N_MASTERS; i++)
            for (int j = 0; j < N_MASTERS; j++)
                if (i < j) v[i*N_MASTERS + j] = 1'b1;
        return v;
    endfunction

    localparam logic [NN-1:0] INIT_ORDER = init_order();

    logic [NN-1:0] older_q;

    // Move the granted master to the most-recent end of the order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            older_q <= INIT_ORDER;
        end else if (|upd_i) begin
            for (int i = 0; i < N_MASTERS; i++) begin
                for (int j = 0; j < N_MASTERS; j++) begin
                    if (i != j) begin
                        if (upd_i[i])
                            older_q[i*N_MASTERS + j] <= 1'b0;
                        else if (upd_i[j])
                            older_q[i*N_MASTERS + j] <= 1'b1;
                    end
                end
            end
        end
    end

    // Select the candidate that is older than every other candidate.
    always_comb begin
        for (int i = 0; i < N_MASTERS; i++) begin
            pick_o[i] = cand_i[i];
            for (int j = 0; j < N_MASTERS; j++) begin
                if (j != i && cand_i[j] && !older_q[i*N_MASTERS + j])
                    pick_o[i] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/parb_tenure_cnt.sv
// Module: parb_tenure_cnt
// Counts outstanding address tenures between start and completion pulses,
// saturating at 0 and MAX_OUT. Exposes both the registered count and the
// count that will hold after this edge.
// Assumes: the bus never completes a tenure that was not started.
module parb_tenure_cnt #(
    parameter int MAX_OUT = 2,
    localparam int CW = $clog2(MAX_OUT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          done_i,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] cnt_next_o,
    output logic          full_next_o
);

    localparam logic [CW-1:0] CMAX = CW'(MAX_OUT);

    logic [CW-1:0] cnt_q;

    // Next count from this cycle's start and completion pulses.
    always_comb begin
        cnt_next_o = cnt_q;
        if (start_i && !done_i && cnt_q != CMAX)
            cnt_next_o = cnt_q + 1'b1;
        else if (done_i && !start_i && cnt_q != '0)
            cnt_next_o = cnt_q - 1'b1;
    end

    // Hold the outstanding count.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_next_o;
    end

    assign cnt_o       = cnt_q;
    assign full_next_o = (cnt_next_o == CMAX);

endmodule

// File: rtl/pipe_bus_arbiter.sv
// Module: pipe_bus_arbiter (top)
// Address-bus arbiter: priority by level, lowest index among ties above 0,
// LRU rotation with one tenure each at level 0, a continuing grant for the
// holder, a gap cycle after each tenure start, a one-level address
// pipeline limit, and three idle parking policies.
// Assumes: tenure_start_i is raised by the granted master only; grants are
// registered, so the output reflects the previous cycle's inputs.
module pipe_bus_arbiter
    import parb_pkg::*;
#(
    parameter int                          N_MASTERS       = 4,
    parameter int                          LVL_W           = 2,
    parameter int                          MAX_OUTSTANDING = 2,
    parameter logic [N_MASTERS*LVL_W-1:0]  DEF_LEVELS      = '0,
    localparam int IDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1,
    localparam int CW    = $clog2(MAX_OUTSTANDING + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_MASTERS-1:0]        req_i,
    output logic [N_MASTERS-1:0]        gnt_o,
    input  logic                        tenure_start_i,
    input  logic                        tenure_done_i,
    input  logic                        addr_retry_i,
    input  logic [N_MASTERS-1:0]        prio_en_i,
    input  logic [N_MASTERS*LVL_W-1:0]  prio_lvl_i,
    input  logic [1:0]                  park_mode_i,
    input  logic [IDX_W-1:0]            park_sel_i
);

    localparam logic [N_MASTERS-1:0] ONE_HOT0 = N_MASTERS'(1);

    logic [N_MASTERS*LVL_W-1:0] lvl_flat;
    logic [LVL_W-1:0]           lvl      [N_MASTERS];
    logic [CW-1:0]              out_cnt;
    logic [CW-1:0]              out_cnt_nxt;
    logic                       blocked;

    logic [N_MASTERS-1:0]       gnt_q, gnt_d;
    logic [IDX_W-1:0]           last_q;
    logic                       gap_q;
    logic                       used_q;

    logic                       any_req;
    logic [LVL_W-1:0]           top_lvl;
    logic [N_MASTERS-1:0]       tie_mask;
    logic [N_MASTERS-1:0]       low_pick;
    logic [N_MASTERS-1:0]       lru_cand;
    logic [N_MASTERS-1:0]       lru_pick;
    logic                       holder_live;
    logic [IDX_W-1:0]           holder_idx;
    logic [IDX_W-1:0]           gnt_d_idx;
    logic                       hold_ok;
    park_mode_e                 park_mode;

    parb_level_regs #(
        .N_MASTERS  (N_MASTERS),
        .LVL_W      (LVL_W),
        .DEF_LEVELS (DEF_LEVELS)
    ) u_levels (
        .clk        (clk),
        .rst_n      (rst_n),
        .prio_en_i  (prio_en_i),
        .prio_lvl_i (prio_lvl_i),
        .lvl_o      (lvl_flat)
    );

    parb_tenure_cnt #(
        .MAX_OUT     (MAX_OUTSTANDING)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (tenure_start_i),
        .done_i      (tenure_done_i),
        .cnt_o       (out_cnt),
        .cnt_next_o  (out_cnt_nxt),
        .full_next_o (blocked)
    );

    parb_lru #(
        .N_MASTERS (N_MASTERS)
    ) u_lru (
        .clk    (clk),
        .rst_n  (rst_n),
        .cand_i (lru_cand),
        .upd_i  (gnt_d),
        .pick_o (lru_pick)
    );

    // Unpack the flat level vector into one entry per master.
    always_comb begin
        for (int m = 0; m < N_MASTERS; m++)
            lvl[m] = lvl_flat[m*LVL_W +: LVL_W];
    end

    // Find the top requesting level and the requesters tied at it.
    always_comb begin
        any_req = |req_i;
        top_lvl = '0;
        for (int m = 0; m < N_MASTERS; m++)
            if (req_i[m] && lvl[m] > top_lvl) top_lvl = lvl[m];
        for (int m = 0; m < N_MASTERS; m++)
            tie_mask[m] = req_i[m] && (lvl[m] == top_lvl);
    end

    // Lowest-index member of the tied set.
    always_comb begin
        low_pick = '0;
        for (int m = N_MASTERS - 1; m >= 0; m--)
            if (tie_mask[m]) low_pick = ONE_HOT0 << m;
    end

    // Only level-0 ties go to the LRU rotation.
    assign lru_cand = (top_lvl == '0) ? tie_mask : '0;

    // Decode the current holder from the registered grant.
    always_comb begin
        holder_live = |gnt_q;
        holder_idx  = '0;
        for (int m = 0; m < N_MASTERS; m++)
            if (gnt_q[m]) holder_idx = IDX_W'(m);
    end

    // Holder continues: requesting, at the top level, no retry, and at
    // level 0 only until its single tenure has started.
    always_comb begin
        hold_ok = holder_live && req_i[holder_idx] &&
                  (lvl[holder_idx] == top_lvl) && !addr_retry_i &&
                  ((top_lvl != '0) || !used_q);
    end

    assign park_mode = park_mode_e'(park_mode_i);

    // Next grant: pipeline limit, gap hold, arbitration, then parking.
    always_comb begin
        gnt_d = '0;
        if (blocked) begin
            gnt_d = '0;
        end else if (gap_q && holder_live && !addr_retry_i) begin
            gnt_d = gnt_q;
        end else if (any_req) begin
            if (hold_ok)
                gnt_d = gnt_q;
            else if (top_lvl != '0)
                gnt_d = low_pick;
            else
                gnt_d = lru_pick;
        end else begin
            case (park_mode)
                PARK_FIXED: gnt_d = ONE_HOT0 << park_sel_i;
                PARK_LAST:  gnt_d = ONE_HOT0 << last_q;
                default:    gnt_d = '0;
            endcase
        end
    end

    // Index of the next grant, for the last-granted record.
    always_comb begin
        gnt_d_idx = '0;
        for (int m = 0; m < N_MASTERS; m++)
            if (gnt_d[m]) gnt_d_idx = IDX_W'(m);
    end

    // Grant register and the holder's per-tenure bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_q  <= '0;
            last_q <= '0;
            gap_q  <= 1'b0;
            used_q <= 1'b0;
        end else begin
            gnt_q <= gnt_d;
            gap_q <= tenure_start_i && holder_live;
            if (|gnt_d)
                last_q <= gnt_d_idx;
            if (gnt_d != gnt_q)
                used_q <= 1'b0;
            else if (tenure_start_i && holder_live)
                used_q <= 1'b1;
        end
    end

    assign gnt_o = gnt_q;

endmodule

// File: rtl/parb_checker.sv
// Module: parb_checker
// Temporal checks on the arbiter's grant against its inputs and pipeline
// state. Bound to every pipe_bus_arbiter instance.
// Assumes: sampled on the arbiter clock with its synchronous reset.
module parb_checker #(
    parameter int N_MASTERS       = 4,
    parameter int MAX_OUTSTANDING = 2,
    parameter int IDX_W           = 2,
    parameter int CW              = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_MASTERS-1:0] req_i,
    input logic [N_MASTERS-1:0] gnt_o,
    input logic                 addr_retry_i,
    input logic [1:0]           park_mode_i,
    input logic [IDX_W-1:0]     park_sel_i,
    input logic [CW-1:0]        out_cnt,
    input logic [CW-1:0]        out_cnt_nxt,
    input logic                 gap_q
);

    assert_gnt_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    assert_idle_no_park_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == '0 && park_mode_i[1] == park_mode_i[0] && !gap_q)
        |=> (gnt_o == '0));

    assert_retry_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_retry_i && req_i == '0 && park_mode_i[1] == park_mode_i[0])
        |=> (gnt_o == '0));

    assert_gap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_q && gnt_o != '0 && !addr_retry_i &&
         int'(out_cnt_nxt) != MAX_OUTSTANDING)
        |=> $stable(gnt_o));

    assert_pipe_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(out_cnt) == MAX_OUTSTANDING) |-> (gnt_o == '0));

    assert_park_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == '0 && park_mode_i == 2'b01 && !gap_q &&
         int'(out_cnt_nxt) != MAX_OUTSTANDING && int'(park_sel_i) < N_MASTERS)
        |=> (gnt_o == (N_MASTERS'(1) << $past(park_sel_i))));

endmodule

bind pipe_bus_arbiter parb_checker #(
    .N_MASTERS       (N_MASTERS),
    .MAX_OUTSTANDING (MAX_OUTSTANDING),
    .IDX_W           (IDX_W),
    .CW              (CW)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .gnt_o        (gnt_o),
    .addr_retry_i (addr_retry_i),
    .park_mode_i  (park_mode_i),
    .park_sel_i   (park_sel_i),
    .out_cnt      (out_cnt),
    .out_cnt_nxt  (out_cnt_nxt),
    .gap_q        (gap_q)
);

// File: tb/pipe_bus_arbiter_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module pipe_bus_arbiter_tb_top;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] req;
    logic [N-1:0] gnt;
    logic         t_start, t_done, retry;
    logic [N-1:0] p_en;
    logic [2*N-1:0] p_lvl;
    logic [1:0]   p_mode;
    logic [1:0]   p_sel;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pipe_bus_arbiter #(.N_MASTERS(N)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_i          (req),
        .gnt_o          (gnt),
        .tenure_start_i (t_start),
        .tenure_done_i  (t_done),
        .addr_retry_i   (retry),
        .prio_en_i      (p_en),
        .prio_lvl_i     (p_lvl),
        .park_mode_i    (p_mode),
        .park_sel_i     (p_sel)
    );

    // One clock edge, then settle on the falling edge for sampling/driving.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_gnt(input logic [N-1:0] exp, input string tag);
        checks++;
        if (gnt !== exp) begin
            errors++;
            $display("FAIL %s: gnt=%b expected %b", tag, gnt, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req = '0; t_start = 0; t_done = 0; retry = 0;
        p_en = '0; p_lvl = '0; p_mode = 2'b00; p_sel = '0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        expect_gnt(4'b0000, "R11 reset grant");
    endtask

    task automatic t_no_park();
        do_reset();
        tick(); expect_gnt(4'b0000, "R1 idle mode 00");
        p_mode = 2'b11; tick(); expect_gnt(4'b0000, "R1 idle mode 11");
    endtask

    task automatic t_priority();
        do_reset();
        p_en = 4'b1111; p_lvl = {2'd2, 2'd3, 2'd3, 2'd1}; // m3..m0
        tick();
        req = 4'b1111; tick();
        expect_gnt(4'b0010, "R2 highest level, lowest index");
    endtask

    task automatic t_hold_retry();
        do_reset();
        p_en = 4'b1111; p_lvl = {2'd0, 2'd2, 2'd2, 2'd2};
        tick();
        req = 4'b0100; tick(); expect_gnt(4'b0100, "R2 single requester");
        req = 4'b0111; tick(); expect_gnt(4'b0100, "R3 holder keeps grant");
        retry = 1'b1; tick(); expect_gnt(4'b0001, "R4 retry re-arbitrates");
        retry = 1'b0;
    endtask

    task automatic t_gap_lru();
        do_reset();
        req = 4'b0001; tick(); expect_gnt(4'b0001, "R6 level-0 first grant");
        t_start = 1'b1; tick(); expect_gnt(4'b0001, "R5 grant through start");
        t_start = 1'b0; req = 4'b0000; tick();
        expect_gnt(4'b0001, "R5 gap cycle holds grant");
        req = 4'b0011; t_done = 1'b1; tick();
        expect_gnt(4'b0010, "R6 pass to least recent level-0");
        t_done = 1'b0; t_start = 1'b1; tick();
        expect_gnt(4'b0010, "R6 second master tenure");
        t_start = 1'b0; tick(); expect_gnt(4'b0010, "R5 gap hold m1");
        tick(); expect_gnt(4'b0001, "R6 rotation back to m0");
    endtask

    task automatic t_levels();
        do_reset();
        p_lvl = {2'd3, 2'd0, 2'd0, 2'd0}; req = 4'b1001;
        tick(); tick();
        expect_gnt(4'b0001, "R7 field ignored while enable 0");
        p_en = 4'b1000; tick();
        expect_gnt(4'b0001, "R7 old level one edge after change");
        tick(); expect_gnt(4'b1000, "R7 new level after two edges");
    endtask

    task automatic t_pipeline();
        do_reset();
        req = 4'b0001; tick();
        t_start = 1'b1; tick(); expect_gnt(4'b0001, "R8 one outstanding");
        tick(); expect_gnt(4'b0000, "R8 grant withheld at two");
        t_start = 1'b0; tick(); expect_gnt(4'b0000, "R8 still full");
        t_done = 1'b1; tick(); expect_gnt(4'b0001, "R8 released on completion");
        t_done = 1'b0;
    endtask

    task automatic t_park_fixed();
        do_reset();
        p_mode = 2'b01; p_sel = 2'd2; tick();
        expect_gnt(4'b0100, "R9 park programmed m2");
        p_sel = 2'd3; tick(); expect_gnt(4'b1000, "R9 park programmed m3");
    endtask

    task automatic t_park_last();
        do_reset();
        p_mode = 2'b10; req = 4'b0010; tick();
        expect_gnt(4'b0010, "R10 granted m1");
        req = 4'b0000; tick(); expect_gnt(4'b0010, "R10 park on last m1");
        p_mode = 2'b00; tick(); expect_gnt(4'b0000, "R1 parking off drops grant");
    endtask

    initial begin
        rst_n = 1'b0;
        @(negedge clk);
        t_reset();
        t_no_park();
        t_priority();
        t_hold_retry();
        t_gap_lru();
        t_levels();
        t_pipeline();
        t_park_fixed();
        t_park_last();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule